// File: doc/BRIEF.md
# Adaptive Prefetch Usefulness Throttle

This block watches what happens to prefetched lines in a single set of a cache tag store. The set keeps more address tags than it has data ways, so an entry can hold an address with no data behind it. Each entry also carries a flag marking a line brought in by a prefetch. The cache controller reports three kinds of events: a line being installed, a demand lookup, and a line being chosen as a victim. From these the block decides whether a prefetch paid off, was wasted, or pushed out data that a later demand access wanted.

Each such verdict moves a saturating budget counter. A prefetch engine reads the counter as the number of prefetches a newly detected stream may issue at startup. When prefetches stop paying off, the budget shrinks towards zero. When they start hitting again, it grows back towards its ceiling. The block also gives a one-cycle pulse for each verdict kind.

Top module: `pfThrottle`

## Requirements
- R1: While `rstN` is low and on the first cycle after release, `startCount` equals `CNT_INIT`, all three verdict pulses are low, and every tag entry is empty (no tag, no data, flag clear).
- R2: An install into slot `allocIdx` stores `allocTag` with its data present, and sets the entry's prefetch flag equal to `allocPrefetch`. A demand-installed line therefore never produces a useful verdict.
- R3: A demand lookup that hits (the tag matches an entry with data present) on an entry whose prefetch flag is set raises `usefulPulse` in the next cycle. It also clears that flag, so a second hit on the same line raises no pulse.
- R4: Victimising slot `evictIdx` while it holds data with the prefetch flag set raises `uselessPulse` in the next cycle. Victimising a slot whose flag is clear, or a slot that holds no data, raises no pulse.
- R5: A demand lookup that misses but matches a tag-only entry raises `harmfulPulse` in the next cycle, provided at least one entry with data present has its prefetch flag set. Without such an entry, the lookup raises no pulse.
- R6: `startCount` moves up by one on a useful verdict and down by one on each useless or harmful verdict. It stays within 0..`CNT_MAX`, saturating at both ends.
- R7: When several verdicts fall in the same cycle, they are combined into one net change (+useful, −useless, −harmful), and the result is clamped to 0..`CNT_MAX`.
- R8: A victimised slot keeps its tag but loses its data. Later lookups of that tag miss, and they are candidates for the harmful verdict.
- R9: All events in one cycle are judged against the entry state before that cycle. Within a slot, an install overrides a victim drop and a flag clear in the same cycle.
- R10: Each verdict pulse lasts exactly one cycle per event. With no events, all pulses are low and `startCount` is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| allocValid | input | 1 | Install a line this cycle |
| allocIdx | input | IDX_W | Tag slot receiving the install |
| allocTag | input | TAG_W | Address tag of the installed line |
| allocPrefetch | input | 1 | Install was issued by the prefetcher |
| evictValid | input | 1 | Victimise a slot this cycle |
| evictIdx | input | IDX_W | Slot losing its data |
| lookupValid | input | 1 | Demand read or write this cycle |
| lookupTag | input | TAG_W | Address tag of the demand access |
| startCount | output | CNT_W | Startup prefetch budget |
| usefulPulse | output | 1 | Useful prefetch verdict |
| uselessPulse | output | 1 | Useless prefetch verdict |
| harmfulPulse | output | 1 | Harmful prefetch verdict |

## Verification
The bench drives both ends of the budget. A design that wraps instead of saturating would jump from zero to the ceiling after a harmful miss, or from the ceiling to zero after a useful hit. Cycles that mix a useful hit with a useless victim check that the verdicts are netted, not prioritised; a design that picked only one would move the count by one instead of holding it. A long pseudo-random sweep over a four-tag set probes the rest:
- Harmful misses must be gated on a flagged line that still has its data. A design that also counted a flagged tag-only entry would report extra harm.
- A hit must clear its flag. A design that left it set would report a useful hit again on every access.
- A prefetch victimised in the same cycle as a reinstall must still be judged useless. A design that judged it after the install would lose that verdict.

// File: rtl/pfThrottlePkg.sv
package pfThrottlePkg;

  // Facts the tag store extracts for the current cycle's events.
  typedef struct packed {
    logic hit;          // lookup matches an entry with data present
    logic hitPf;        // that entry carries the prefetch flag
    logic tagOnlyMatch; // lookup matches an entry holding only a tag
    logic anyPfValid;   // some entry with data has its prefetch flag set
    logic evictHadPf;   // victim slot holds flagged data
  } tagInfoT;

  // Strobes the classifier sends back to the tag store.
  typedef struct packed {
    logic clearHitPf;
  } tagStrobeT;

  typedef struct packed {
    logic useful;
    logic useless;
    logic harmful;
  } verdictT;

endpackage

// File: rtl/pfTagStore.sv
module pfTagStore
  import pfThrottlePkg::*;
#(
  parameter int NUM_TAGS  = 16,
  parameter int DATA_WAYS = 8,
  parameter int TAG_W     = 20,
  parameter int IDX_W     = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             allocValid,
  input  logic [IDX_W-1:0] allocIdx,
  input  logic [TAG_W-1:0] allocTag,
  input  logic             allocPrefetch,
  input  logic             evictValid,
  input  logic [IDX_W-1:0] evictIdx,
  input  logic [TAG_W-1:0] lookupTag,
  input  tagStrobeT        strobe,
  output tagInfoT          info
);

  logic [NUM_TAGS-1:0] tagValidVec;
  logic [NUM_TAGS-1:0] dataValidVec;
  logic [NUM_TAGS-1:0] pfVec;
  logic [NUM_TAGS-1:0] matchVec;
  logic [NUM_TAGS-1:0] hitVec;
  logic [NUM_TAGS-1:0] allocHereVec;
  logic [NUM_TAGS-1:0] evictHereVec;

  assign hitVec = matchVec & dataValidVec;

  for (genvar i = 0; i < NUM_TAGS; i++) begin : gEntry
    logic             eTagV;
    logic             eDataV;
    logic             ePf;
    logic [TAG_W-1:0] eTag;

    assign allocHereVec[i] = allocValid && (allocIdx == IDX_W'(i));
    assign evictHereVec[i] = evictValid && (evictIdx == IDX_W'(i));

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        eTagV  <= 1'b0;
        eDataV <= 1'b0;
        ePf    <= 1'b0;
        eTag   <= '0;
      end else if (allocHereVec[i]) begin
        eTagV  <= 1'b1;
        eDataV <= 1'b1;
        ePf    <= allocPrefetch;
        eTag   <= allocTag;
      end else if (evictHereVec[i]) begin
        eDataV <= 1'b0;
        ePf    <= 1'b0;
      end else if (strobe.clearHitPf && hitVec[i]) begin
        ePf    <= 1'b0;
      end
    end

    assign tagValidVec[i]  = eTagV;
    assign dataValidVec[i] = eDataV;
    assign pfVec[i]        = ePf;
    assign matchVec[i]     = eTagV && (eTag == lookupTag);
  end

  always_comb begin
    info.hit          = |hitVec;
    info.hitPf        = |(hitVec & pfVec);
    info.tagOnlyMatch = |(matchVec & ~dataValidVec);
    info.anyPfValid   = |(dataValidVec & pfVec);
    info.evictHadPf   = |(evictHereVec & dataValidVec & pfVec);
  end

  // Tags in a set are unique, so at most one entry can match (R3).
  p_unique_match_r3: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(matchVec));

  // Data presence never exceeds the number of data ways (R8).
  p_data_cap_r8: assert property (@(posedge clk) disable iff (!rstN)
    $countones(dataValidVec) <= DATA_WAYS);

  // An install copies the prefetch origin into the flag (R2).
  p_alloc_flag_r2: assert property (@(posedge clk) disable iff (!rstN)
    allocValid |=> (pfVec[$past(allocIdx)] == $past(allocPrefetch)));

  // A demand hit leaves its line unflagged unless reinstalled (R3).
  p_hit_clears_r3: assert property (@(posedge clk) disable iff (!rstN)
    strobe.clearHitPf |=> (($past(hitVec) & ~$past(allocHereVec) & pfVec) == '0));

  // A victim keeps no data unless reinstalled the same cycle (R4, R8).
  p_evict_drops_r4: assert property (@(posedge clk) disable iff (!rstN)
    evictValid |=> (($past(evictHereVec) & ~$past(allocHereVec) & dataValidVec) == '0));

  // A victimised slot still holds its tag (R8).
  p_tag_kept_r8: assert property (@(posedge clk) disable iff (!rstN)
    evictValid && $past(rstN) |=> (($past(evictHereVec) & $past(tagValidVec) & ~tagValidVec) == '0));

endmodule

// File: rtl/pfClassifier.sv
module pfClassifier
  import pfThrottlePkg::*;
(
  input  logic      lookupValid,
  input  tagInfoT   info,
  output tagStrobeT strobe,
  output verdictT   verdict
);

  logic demandHit;
  logic demandMiss;

  assign demandHit  = lookupValid && info.hit;
  assign demandMiss = lookupValid && !info.hit;

  always_comb begin
    strobe.clearHitPf = demandHit;
    verdict.useful    = demandHit && info.hitPf;
    verdict.useless   = info.evictHadPf;
    verdict.harmful   = demandMiss && info.tagOnlyMatch && info.anyPfValid;
  end

endmodule

// File: rtl/pfSatCounter.sv
module pfSatCounter
  import pfThrottlePkg::*;
#(
  parameter int CNT_MAX  = 15,
  parameter int CNT_INIT = 15,
  parameter int CNT_W    = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  verdictT          verdict,
  output logic [CNT_W-1:0] count,
  output logic             usefulPulse,
  output logic             uselessPulse,
  output logic             harmfulPulse
);

  localparam int SW = CNT_W + 2;

  logic [SW-1:0]    upSum;
  logic [SW-1:0]    downSum;
  logic [CNT_W-1:0] nextCount;

  always_comb begin
    upSum   = SW'(count) + SW'(verdict.useful);
    downSum = SW'(verdict.useless) + SW'(verdict.harmful);
    if (upSum < downSum)
      nextCount = '0;
    else if ((upSum - downSum) > SW'(CNT_MAX))
      nextCount = CNT_W'(CNT_MAX);
    else
      nextCount = CNT_W'(upSum - downSum);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      count        <= CNT_W'(CNT_INIT);
      usefulPulse  <= 1'b0;
      uselessPulse <= 1'b0;
      harmfulPulse <= 1'b0;
    end else begin
      count        <= nextCount;
      usefulPulse  <= verdict.useful;
      uselessPulse <= verdict.useless;
      harmfulPulse <= verdict.harmful;
    end
  end

  p_bound_r6: assert property (@(posedge clk) disable iff (!rstN)
    count <= CNT_W'(CNT_MAX));

  // Growth only comes from a lone useful verdict (R6, R7).
  p_rise_r6: assert property (@(posedge clk) disable iff (!rstN)
    (count > $past(count)) |-> (usefulPulse && !uselessPulse && !harmfulPulse));

  // Shrinkage needs a negative verdict (R6, R7).
  p_fall_r7: assert property (@(posedge clk) disable iff (!rstN)
    (count < $past(count)) |-> (uselessPulse || harmfulPulse));

  // Quiet cycles leave the budget alone (R10).
  p_idle_r10: assert property (@(posedge clk) disable iff (!rstN)
    (!usefulPulse && !uselessPulse && !harmfulPulse) |-> $stable(count));

endmodule

// File: rtl/pfThrottle.sv
module pfThrottle
  import pfThrottlePkg::*;
#(
  parameter int DATA_WAYS = 8,
  parameter int TAG_W     = 20,
  parameter int CNT_MAX   = 15,
  parameter int CNT_INIT  = 15,
  localparam int NUM_TAGS = 2 * DATA_WAYS,
  localparam int IDX_W    = $clog2(NUM_TAGS),
  localparam int CNT_W    = $clog2(CNT_MAX + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             allocValid,
  input  logic [IDX_W-1:0] allocIdx,
  input  logic [TAG_W-1:0] allocTag,
  input  logic             allocPrefetch,
  input  logic             evictValid,
  input  logic [IDX_W-1:0] evictIdx,
  input  logic             lookupValid,
  input  logic [TAG_W-1:0] lookupTag,
  output logic [CNT_W-1:0] startCount,
  output logic             usefulPulse,
  output logic             uselessPulse,
  output logic             harmfulPulse
);

  tagInfoT   info;
  tagStrobeT strobe;
  verdictT   verdict;

  pfTagStore #(
    .NUM_TAGS (NUM_TAGS),
    .DATA_WAYS(DATA_WAYS),
    .TAG_W    (TAG_W),
    .IDX_W    (IDX_W)
  ) uTagStore (
    .clk          (clk),
    .rstN         (rstN),
    .allocValid   (allocValid),
    .allocIdx     (allocIdx),
    .allocTag     (allocTag),
    .allocPrefetch(allocPrefetch),
    .evictValid   (evictValid),
    .evictIdx     (evictIdx),
    .lookupTag    (lookupTag),
    .strobe       (strobe),
    .info         (info)
  );

  pfClassifier uClassifier (
    .lookupValid(lookupValid),
    .info       (info),
    .strobe     (strobe),
    .verdict    (verdict)
  );

  pfSatCounter #(
    .CNT_MAX (CNT_MAX),
    .CNT_INIT(CNT_INIT),
    .CNT_W   (CNT_W)
  ) uCounter (
    .clk         (clk),
    .rstN        (rstN),
    .verdict     (verdict),
    .count       (startCount),
    .usefulPulse (usefulPulse),
    .uselessPulse(uselessPulse),
    .harmfulPulse(harmfulPulse)
  );

  // Hit and miss are exclusive, so one lookup cannot be both useful and harmful (R3, R5).
  p_verdict_excl_r5: assert property (@(posedge clk) disable iff (!rstN)
    !(usefulPulse && harmfulPulse));

endmodule

// File: tb/pfThrottle_test.sv
`timescale 1ns/1ps
module pfThrottle_test;

  localparam int DW = 2;
  localparam int NT = 2 * DW;
  localparam int TW = 4;
  localparam int CM = 3;
  localparam int CI = 3;
  localparam int IW = 2;
  localparam int CW = 2;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          allocValid = 1'b0;
  logic [IW-1:0] allocIdx = '0;
  logic [TW-1:0] allocTag = '0;
  logic          allocPrefetch = 1'b0;
  logic          evictValid = 1'b0;
  logic [IW-1:0] evictIdx = '0;
  logic          lookupValid = 1'b0;
  logic [TW-1:0] lookupTag = '0;
  logic [CW-1:0] startCount;
  logic          usefulPulse, uselessPulse, harmfulPulse;

  int compared = 0;
  int mismatched = 0;
  bit done = 1'b0;

  bit          mTV[NT];
  bit          mDV[NT];
  bit          mPf[NT];
  logic [TW-1:0] mTag[NT];
  int          mCount;
  logic [31:0] lfsr = 32'hACE1_1234;

  always #2 clk = ~clk;

  pfThrottle #(.DATA_WAYS(DW), .TAG_W(TW), .CNT_MAX(CM), .CNT_INIT(CI)) uut (
    .clk(clk), .rstN(rstN),
    .allocValid(allocValid), .allocIdx(allocIdx), .allocTag(allocTag),
    .allocPrefetch(allocPrefetch),
    .evictValid(evictValid), .evictIdx(evictIdx),
    .lookupValid(lookupValid), .lookupTag(lookupTag),
    .startCount(startCount), .usefulPulse(usefulPulse),
    .uselessPulse(uselessPulse), .harmfulPulse(harmfulPulse)
  );

  task automatic chk(input string what, input int act, input int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  task automatic checkAll(input string tag, input int eU, input int eL, input int eH);
    chk({tag, " R6 count"}, int'(startCount), mCount);
    chk({tag, " R3 useful"}, int'(usefulPulse), eU);
    chk({tag, " R4 useless"}, int'(uselessPulse), eL);
    chk({tag, " R5 harmful"}, int'(harmfulPulse), eH);
  endtask

  // Drive one cycle of events at a falling edge, predict, and check at the next falling edge.
  task automatic step(input bit aV, input int aI, input logic [TW-1:0] aT, input bit aP,
                      input bit eV, input int eI, input bit lV, input logic [TW-1:0] lT,
                      input string tag);
    int hitI;
    bit tagOnly, anyPf;
    int u, ul, h;
    allocValid = aV; allocIdx = IW'(aI); allocTag = aT; allocPrefetch = aP;
    evictValid = eV; evictIdx = IW'(eI);
    lookupValid = lV; lookupTag = lT;
    hitI = -1; tagOnly = 0; anyPf = 0;
    for (int i = 0; i < NT; i++) begin
      if (mTV[i] && mTag[i] == lT) begin
        if (mDV[i]) hitI = i; else tagOnly = 1;
      end
      if (mDV[i] && mPf[i]) anyPf = 1;
    end
    u  = (lV && hitI >= 0 && mPf[hitI]) ? 1 : 0;
    h  = (lV && hitI < 0 && tagOnly && anyPf) ? 1 : 0;
    ul = (eV && mDV[eI] && mPf[eI]) ? 1 : 0;
    if (lV && hitI >= 0) mPf[hitI] = 0;
    if (eV) begin mDV[eI] = 0; mPf[eI] = 0; end
    if (aV) begin mTV[aI] = 1; mDV[aI] = 1; mPf[aI] = aP; mTag[aI] = aT; end
    mCount = mCount + u - ul - h;
    if (mCount < 0) mCount = 0;
    if (mCount > CM) mCount = CM;
    @(negedge clk);
    checkAll(tag, u, ul, h);
  endtask

  task automatic idle(input string tag);
    step(0, 0, '0, 0, 0, 0, 0, '0, tag);
  endtask

  initial begin
    for (int i = 0; i < NT; i++) begin mTV[i] = 0; mDV[i] = 0; mPf[i] = 0; mTag[i] = '0; end
    mCount = CI;
    repeat (3) @(negedge clk);
    checkAll("R1 reset held", 0, 0, 0);
    rstN = 1'b1;
    idle("R1 after release");
    // Empty set: no entry can match, so nothing fires (R1).
    step(0, 0, '0, 0, 1, 2, 1, 4'h6, "R1 empty set");

    // Prefetch install then demand hits (R2, R3); budget pinned at ceiling (R6).
    step(1, 0, 4'h1, 1, 0, 0, 0, '0, "R2 pf install");
    step(0, 0, '0, 0, 0, 0, 1, 4'h1, "R3 first hit useful");
    step(0, 0, '0, 0, 0, 0, 1, 4'h1, "R3 second hit plain");
    idle("R10 quiet");
    step(1, 1, 4'h5, 0, 0, 0, 0, '0, "R2 demand install");
    step(0, 0, '0, 0, 0, 0, 1, 4'h5, "R2 demand line no verdict");
    step(0, 0, '0, 0, 1, 1, 0, '0, "R4 unflagged victim");
    step(0, 0, '0, 0, 1, 1, 0, '0, "R4 tag-only victim");

    // Useless prefetch (R4).
    step(1, 2, 4'h9, 1, 0, 0, 0, '0, "R2 pf install slot2");
    step(0, 0, '0, 0, 1, 2, 0, '0, "R4 flagged victim");
    // Tag-only miss without flagged data: no harm (R5, R8).
    step(0, 0, '0, 0, 0, 0, 1, 4'h5, "R5 no flagged data");
    // Harmful misses down to the floor (R5, R6, R8).
    step(1, 3, 4'hD, 1, 0, 0, 0, '0, "R2 pf install slot3");
    step(0, 0, '0, 0, 0, 0, 1, 4'h5, "R5 harmful one");
    step(0, 0, '0, 0, 0, 0, 1, 4'h9, "R8 evicted tag misses");
    step(0, 0, '0, 0, 0, 0, 1, 4'h5, "R6 floor saturation");
    step(0, 0, '0, 0, 0, 0, 1, 4'h7, "R5 unknown tag");
    idle("R10 pulses drop");

    // Netting of simultaneous verdicts (R7).
    step(1, 0, 4'h1, 1, 0, 0, 0, '0, "R9 reinstall slot0");
    step(0, 0, '0, 0, 1, 3, 1, 4'h1, "R7 useful plus useless");
    step(1, 3, 4'hC, 1, 0, 0, 0, '0, "R2 pf install slot3 again");
    step(0, 0, '0, 0, 0, 0, 1, 4'hC, "R6 rise from floor");
    // Install overrides a same-cycle hit clear (R9).
    step(1, 0, 4'h2, 1, 0, 0, 0, '0, "R9 setup slot0");
    step(1, 0, 4'h3, 1, 0, 0, 1, 4'h2, "R9 install beats hit clear");
    step(0, 0, '0, 0, 0, 0, 1, 4'h3, "R9 new line still flagged");
    // Install and victim on one flagged slot: judged on old state (R9, R4).
    step(1, 0, 4'h0, 1, 0, 0, 0, '0, "R9 setup flagged");
    step(1, 0, 4'h1, 0, 1, 0, 0, '0, "R9 victim then install");
    step(0, 0, '0, 0, 0, 0, 1, 4'h1, "R9 demand install not useful");
    idle("R10 quiet end");

    // Pseudo-random sweep honouring the data-way limit.
    for (int n = 0; n < 4000; n++) begin
      bit aV, aP, eV, lV, slotHas;
      int aI, eI, cnt;
      logic [TW-1:0] aT, lT;
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      lV = lfsr[2] | lfsr[3];
      lT = lfsr[7:4];
      eV = lfsr[8] & (lfsr[9] | lfsr[18]);
      eI = int'(lfsr[11:10]);
      aV = lfsr[12];
      aI = int'(lfsr[14:13]);
      aT = {lfsr[14:13], lfsr[16:15]};
      aP = lfsr[17] | lfsr[19];
      cnt = 0;
      for (int i = 0; i < NT; i++) if (mDV[i] && !(eV && eI == i)) cnt++;
      slotHas = mDV[aI] && !(eV && eI == aI);
      if (aV && !slotHas && cnt >= DW) aV = 0;
      step(aV, aI, aT, aP, eV, eI, lV, lT, "R7 sweep");
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

endmodule